// File: doc/BRIEF.md
# Fractional Multiply-Accumulate with Rounding

This block performs one signed fractional multiply-accumulate step with rounding. Two 16-bit words are read as signed Q15 fractions and multiplied. The product is doubled to give a Q31 value. That value is added to, or subtracted from, a 40-bit accumulator that carries eight guard bits. The sum is then rounded at a bit position set by the scaling field, and every bit below that position is cleared. The result, a limit indication and a sticky overflow flag come back one clock later.

A control bit selects one of two rounding rules: ties-to-even or ties-up. A saturation-mode control clamps any result outside the signed 32-bit range to the largest or smallest value that has a zero low word. When saturation mode is off, the limit bit reports whether the result still fits the 32-bit range. The overflow flag collects events across operations and keeps them until a clear input removes them. The register file, instruction decode and stall logic sit outside this block.

Top module: `frac_mac_rnd`

## Requirements
- R1: The result is `acc_in + 2*(op_a*op_b)` when `op_sub`=0 and `acc_in - 2*(op_a*op_b)` when `op_sub`=1. Both operands are signed 16-bit values and the arithmetic is 40-bit two's complement; rounding then follows R3 to R5.
- R2: For `op_a`=`op_b`=16'h8000 the product is replaced by 0x7FFF_FFFF when `sat_en`=1. When `sat_en`=0 the product is the exact +1.0 value 0x00_8000_0000.
- R3: With `rnd_twos`=0, a value whose discarded part is exactly one half rounds to the neighbour whose lowest kept bit is 0. Other values round to nearest. All discarded bits of the result are 0.
- R4: With `rnd_twos`=1, a value whose discarded part is exactly one half rounds upward, toward plus infinity.
- R5: `scale_mode` sets the lowest kept bit: 2'b00 and 2'b11 keep bit 16, 2'b01 keeps bit 17, and 2'b10 keeps bit 15.
- R6: With `sat_en`=1, a rounded result above 2^31-1 becomes 40'h00_7FFF_0000 and one below -2^31 becomes 40'hFF_8000_0000. `lim_out` is 0 whenever `sat_en`=1.
- R7: With `sat_en`=0, `lim_out`=1 exactly when bits [39:L] of the result are not all equal. L is 31 for `scale_mode` 2'b00 and 2'b11, 32 for 2'b01, and 30 for 2'b10.
- R8: The event that sets `ovf_sticky` is a rounded result outside the 40-bit range (the stored result then keeps only its low 40 bits) or a saturation under R6. `ovf_clr` clears the flag; if an event occurs in the same cycle as `ovf_clr`, the flag ends set.
- R9: The outputs update on the clock edge that samples `op_valid`=1, and `res_valid` is high for that one cycle. When `op_valid`=0, `acc_out` and `lim_out` hold their values.
- R10: After reset, `acc_out`, `lim_out`, `ovf_sticky` and `res_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_valid | input | 1 | Starts one operation this cycle |
| op_sub | input | 1 | 1 subtracts the product, 0 adds it |
| sat_en | input | 1 | 32-bit saturation mode |
| rnd_twos | input | 1 | 1 ties round up, 0 ties round to even |
| scale_mode | input | 2 | Scaling mode that picks the rounding and limit positions |
| op_a | input | 16 | First fractional operand (high word of a source register) |
| op_b | input | 16 | Second fractional operand |
| acc_in | input | 40 | Current accumulator value |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| acc_out | output | 40 | Rounded accumulator result |
| lim_out | output | 1 | Limit bit of the result |
| ovf_sticky | output | 1 | Sticky overflow flag |
| res_valid | output | 1 | A result was written in the previous cycle |

## Verification
The hardest case to reach from the ports is the clamp of the -1 x -1 product. Rounding usually absorbs the one-LSB difference between the clamped and the exact product, so most stimulus cannot tell them apart. The bench chooses the accumulator 0xFF_FFFF_8000 so that the exact product would land on a tie, round up and saturate. The clamped product stays just below the tie, so the overflow flag tells the two cases apart. Exact ties under each scaling position and both rounding rules come from operands chosen so that the doubled product fills the discarded bits with exactly one half.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  parameter int FM_OPW  = 16;
  parameter int FM_ACCW = 40;
  parameter int FM_SATW = 32;
  parameter int FM_RNDW = 16;

  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;
endpackage

// File: rtl/fmac_mul.sv
module fmac_mul #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic signed [OPW-1:0]  op_a,
  input  logic signed [OPW-1:0]  op_b,
  input  logic                   sat_en,
  output logic        [ACCW-1:0] prod_ext
);
  localparam int PW = 2 * OPW;
  localparam logic [OPW-1:0] MINV = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [ACCW-1:0] CLAMP = {{(ACCW-PW+1){1'b0}}, {(PW-1){1'b1}}};

  logic signed [PW-1:0] raw;
  logic        [PW:0]   frac;
  logic                 corner;

  always_comb begin
    raw    = op_a * op_b;
    frac   = {raw, 1'b0};
    corner = (op_a == MINV) && (op_b == MINV);
    if (sat_en && corner) prod_ext = CLAMP;
    else                  prod_ext = {{(ACCW-PW-1){frac[PW]}}, frac};
  end
endmodule

// File: rtl/fmac_addsub.sv
module fmac_addsub #(
  parameter int ACCW = 40
) (
  input  logic [ACCW-1:0] acc_in,
  input  logic [ACCW-1:0] prod,
  input  logic            sub,
  output logic [ACCW:0]   sum
);
  logic [ACCW:0] acc_x, prod_x;

  always_comb begin
    acc_x  = {acc_in[ACCW-1], acc_in};
    prod_x = {prod[ACCW-1], prod};
    sum    = sub ? (acc_x - prod_x) : (acc_x + prod_x);
  end
endmodule

// File: rtl/fmac_round.sv
module fmac_round
  import fmac_pkg::*;
#(
  parameter int W    = 41,
  parameter int RNDW = 16
) (
  input  logic [W-1:0] val,
  input  logic [1:0]   scale_mode,
  input  logic         twos,
  output logic [W-1:0] rnd
);
  logic [W-1:0] cand [3];

  for (genvar g = 0; g < 3; g++) begin : g_pos
    localparam int K = RNDW - 1 + g;
    localparam logic [W-1:0] HALF = W'(1) << (K - 1);
    localparam logic [W-1:0] LOWM = (HALF << 1) - W'(1);
    logic [W-1:0] sum_h;
    logic         tie;
    assign sum_h   = val + HALF;
    assign tie     = (val & LOWM) == HALF;
    assign cand[g] = (sum_h & ~LOWM) & ~((tie && !twos) ? (HALF << 1) : '0);
  end

  always_comb begin
    unique case (scale_e'(scale_mode))
      SCL_UP:   rnd = cand[0];
      SCL_DOWN: rnd = cand[2];
      default:  rnd = cand[1];
    endcase
  end
endmodule

// File: rtl/fmac_satlim.sv
module fmac_satlim
  import fmac_pkg::*;
#(
  parameter int ACCW = 40,
  parameter int SATW = 32,
  parameter int RNDW = 16
) (
  input  logic [ACCW:0]   rnd,
  input  logic            sat_en,
  input  logic [1:0]      scale_mode,
  output logic [ACCW-1:0] res,
  output logic            lim,
  output logic            ovf_evt
);
  localparam logic [ACCW-1:0] POS_LIM = ACCW'((64'd1 << (SATW-1)) - (64'd1 << RNDW));
  localparam logic [ACCW-1:0] NEG_LIM = ~ACCW'((64'd1 << (SATW-1)) - 64'd1);

  logic [ACCW-SATW+1:0] guard;
  logic ovf_wide, fits32, do_sat;
  logic l_none, l_down, l_up;

  always_comb begin
    guard    = rnd[ACCW:SATW-1];
    ovf_wide = rnd[ACCW] ^ rnd[ACCW-1];
    fits32   = (&guard) || !(|guard);
    do_sat   = sat_en && !fits32;
    if (do_sat) res = rnd[ACCW] ? NEG_LIM : POS_LIM;
    else        res = rnd[ACCW-1:0];
    l_none = !((&res[ACCW-1:SATW-1]) || !(|res[ACCW-1:SATW-1]));
    l_down = !((&res[ACCW-1:SATW])   || !(|res[ACCW-1:SATW]));
    l_up   = !((&res[ACCW-1:SATW-2]) || !(|res[ACCW-1:SATW-2]));
    if (sat_en) lim = 1'b0;
    else begin
      unique case (scale_e'(scale_mode))
        SCL_DOWN: lim = l_down;
        SCL_UP:   lim = l_up;
        default:  lim = l_none;
      endcase
    end
    ovf_evt = ovf_wide || do_sat;
  end
endmodule

// File: rtl/frac_mac_rnd.sv
module frac_mac_rnd
  import fmac_pkg::*;
#(
  parameter int OPW  = FM_OPW,
  parameter int ACCW = FM_ACCW,
  parameter int SATW = FM_SATW,
  parameter int RNDW = FM_RNDW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic            op_sub,
  input  logic            sat_en,
  input  logic            rnd_twos,
  input  logic [1:0]      scale_mode,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  input  logic [ACCW-1:0] acc_in,
  input  logic            ovf_clr,
  output logic [ACCW-1:0] acc_out,
  output logic            lim_out,
  output logic            ovf_sticky,
  output logic            res_valid
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [ACCW-1:0] prod;
  logic [ACCW:0]   sum, rnd;
  logic [ACCW-1:0] res;
  logic            lim, ovf_evt;

  fmac_mul #(.OPW(OPW), .ACCW(ACCW)) u_mul (
    .op_a(op_a), .op_b(op_b), .sat_en(sat_en), .prod_ext(prod)
  );

  fmac_addsub #(.ACCW(ACCW)) u_add (
    .acc_in(acc_in), .prod(prod), .sub(op_sub), .sum(sum)
  );

  fmac_round #(.W(ACCW+1), .RNDW(RNDW)) u_rnd (
    .val(sum), .scale_mode(scale_mode), .twos(rnd_twos), .rnd(rnd)
  );

  fmac_satlim #(.ACCW(ACCW), .SATW(SATW), .RNDW(RNDW)) u_sat (
    .rnd(rnd), .sat_en(sat_en), .scale_mode(scale_mode),
    .res(res), .lim(lim), .ovf_evt(ovf_evt)
  );

  logic [ACCW-1:0] acc_q, acc_d;
  logic            lim_q, lim_d, ovf_q, ovf_d, vld_q, vld_d;

  always_comb begin
    acc_d = acc_q;
    lim_d = lim_q;
    if (op_valid) begin
      acc_d = res;
      lim_d = lim;
    end
    ovf_d = (ovf_q && !ovf_clr) || (op_valid && ovf_evt);
    vld_d = op_valid;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      acc_q <= '0;
      lim_q <= 1'b0;
      ovf_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      lim_q <= lim_d;
      ovf_q <= ovf_d;
      vld_q <= vld_d;
    end
  end

  assign acc_out    = acc_q;
  assign lim_out    = lim_q;
  assign ovf_sticky = ovf_q;
  assign res_valid  = vld_q;
endmodule

// File: rtl/frac_mac_rnd_chk.sv
module frac_mac_rnd_chk #(
  parameter int ACCW = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            sat_en,
  input logic            ovf_clr,
  input logic [ACCW-1:0] acc_out,
  input logic            lim_out,
  input logic            ovf_sticky,
  input logic            res_valid
);
  p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_out) && $stable(lim_out) && !res_valid));

  p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (acc_out[14:0] == '0));

  p_sat_lim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sat_en) |=> !lim_out);

  p_sat_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sat_en) |=> ((&acc_out[ACCW-1:31]) || !(|acc_out[ACCW-1:31])));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clr) |=> ovf_sticky);

  p_idle_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_sticky && !op_valid) |=> !ovf_sticky);
endmodule

bind frac_mac_rnd frac_mac_rnd_chk #(.ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .op_valid(op_valid), .sat_en(sat_en),
  .ovf_clr(ovf_clr), .acc_out(acc_out), .lim_out(lim_out),
  .ovf_sticky(ovf_sticky), .res_valid(res_valid)
);

// File: tb/sim_frac_mac_rnd.sv
module sim_frac_mac_rnd;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_sub, sat_en, rnd_twos, ovf_clr;
  logic [1:0]  scale_mode;
  logic [15:0] op_a, op_b;
  logic [39:0] acc_in;
  logic [39:0] acc_out;
  logic        lim_out, ovf_sticky, res_valid;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 0;

  typedef struct packed {
    logic [39:0] acc;
    logic        lim;
    logic        ovf;
    logic        vld;
  } exp_t;

  exp_t exp_q[$];
  exp_t st;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_mac_rnd u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
    .sat_en(sat_en), .rnd_twos(rnd_twos), .scale_mode(scale_mode),
    .op_a(op_a), .op_b(op_b), .acc_in(acc_in), .ovf_clr(ovf_clr),
    .acc_out(acc_out), .lim_out(lim_out), .ovf_sticky(ovf_sticky),
    .res_valid(res_valid)
  );

  function automatic longint sx40(input logic [39:0] v);
    return longint'({{24{v[39]}}, v});
  endfunction

  function automatic void model(input logic [15:0] a, input logic [15:0] b,
                                input logic [39:0] acc, input logic sub,
                                input logic sat, input logic twos,
                                input logic [1:0] sc,
                                output logic [39:0] o, output logic l,
                                output logic ev);
    longint p, s, unit, half, rem, base, r;
    int k, lo;
    bit up, same;
    p = longint'($signed(a)) * longint'($signed(b)) * 2;
    if (sat && a == 16'h8000 && b == 16'h8000) p = 64'sh7FFF_FFFF;
    s = sub ? sx40(acc) - p : sx40(acc) + p;
    k = (sc == 2'b01) ? 17 : (sc == 2'b10) ? 15 : 16;
    unit = 64'sd1 <<< k;
    half = unit >>> 1;
    rem  = s & (unit - 1);
    base = s - rem;
    up   = (rem > half) || (rem == half && (twos || ((base >>> k) & 1) == 1));
    r    = base + (up ? unit : 0);
    if (sat && (r > 64'sh7FFF_FFFF || r < -64'sh8000_0000)) begin
      o  = (r > 0) ? 40'h00_7FFF_0000 : 40'hFF_8000_0000;
      ev = 1'b1;
      l  = 1'b0;
    end else begin
      o  = r[39:0];
      ev = (r > 64'sh7F_FFFF_FFFF) || (r < -64'sh80_0000_0000);
      lo = (sc == 2'b01) ? 32 : (sc == 2'b10) ? 30 : 31;
      same = 1'b1;
      for (int i = lo; i < 40; i++) if (o[i] != o[39]) same = 1'b0;
      l = sat ? 1'b0 : !same;
    end
  endfunction

  task automatic check_bit(input string tag, input logic got, input logic exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_acc(input string tag, input logic [39:0] got, input logic [39:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %010h expected %010h at %0t", tag, got, exp, $time);
    end
  endtask

  // Called at a falling edge; applies inputs, updates model at the rising edge,
  // compares at the next falling edge.
  task automatic step(input string tag, input logic v, input logic [15:0] a,
                      input logic [15:0] b, input logic [39:0] acc,
                      input logic sub, input logic sat, input logic twos,
                      input logic [1:0] sc, input logic clr);
    logic [39:0] o; logic l, ev; exp_t e;
    op_valid = v; op_a = a; op_b = b; acc_in = acc; op_sub = sub;
    sat_en = sat; rnd_twos = twos; scale_mode = sc; ovf_clr = clr;
    @(posedge clk);
    model(a, b, acc, sub, sat, twos, sc, o, l, ev);
    if (v) begin st.acc = o; st.lim = l; end
    st.ovf = (st.ovf && !clr) || (v && ev);
    st.vld = v;
    exp_q.push_back(st);
    @(negedge clk);
    e = exp_q.pop_front();
    check_acc({tag, " acc"}, acc_out, e.acc);
    check_bit({tag, " lim R7"}, lim_out, e.lim);
    check_bit({tag, " ovf R8"}, ovf_sticky, e.ovf);
    check_bit({tag, " valid R9"}, res_valid, e.vld);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_valid = 0; op_sub = 0; sat_en = 0; rnd_twos = 0; ovf_clr = 0;
    scale_mode = 0; op_a = 0; op_b = 0; acc_in = 0;
    st = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check_acc("R10 reset acc", acc_out, 40'h0);
    check_bit("R10 reset lim", lim_out, 1'b0);
    check_bit("R10 reset ovf", ovf_sticky, 1'b0);
    check_bit("R10 reset valid", res_valid, 1'b0);

    // R1 worked example: 0x0080*0x0080 doubled, add to 0x0007_0000
    step("R1 example", 1, 16'h0080, 16'h0080, 40'h00_0007_0000, 0, 0, 0, 2'b00, 0);
    check_acc("R1 example direct", acc_out, 40'h00_0008_0000);
    // R1 subtract
    step("R1 sub", 1, 16'h4000, 16'h2000, 40'h00_1234_0000, 1, 0, 0, 2'b00, 0);
    // R3 tie to even (round down), R4 tie up
    step("R3 tie even", 1, 16'h0080, 16'h0080, 40'h00_0006_0000, 0, 0, 0, 2'b00, 0);
    check_acc("R3 tie even direct", acc_out, 40'h00_0006_0000);
    step("R4 tie up", 1, 16'h0080, 16'h0080, 40'h00_0006_0000, 0, 0, 1, 2'b00, 0);
    check_acc("R4 tie up direct", acc_out, 40'h00_0007_0000);
    step("R4 neg tie", 1, 16'h0080, 16'h0080, 40'hFF_FFFA_0000, 1, 0, 1, 2'b00, 0);
    // R5 scaling positions with exact ties
    step("R5 down tie", 1, 16'h0100, 16'h0080, 40'h00_0002_0000, 0, 0, 0, 2'b01, 0);
    step("R5 down tie2", 1, 16'h0100, 16'h0080, 40'h00_0006_0000, 0, 0, 0, 2'b01, 0);
    step("R5 up tie", 1, 16'h0040, 16'h0080, 40'h00_0001_8000, 0, 0, 0, 2'b10, 0);
    step("R5 up tie twos", 1, 16'h0040, 16'h0080, 40'h00_0001_0000, 0, 0, 1, 2'b10, 0);
    step("R5 reserved", 1, 16'h0080, 16'h0080, 40'h00_0003_0000, 0, 0, 0, 2'b11, 0);
    // R7 limit per scaling
    step("R7 lim none", 1, 16'h4000, 16'h4000, 40'h00_7000_0000, 0, 0, 0, 2'b00, 0);
    check_bit("R7 lim none direct", lim_out, 1'b1);
    step("R7 lim down", 1, 16'h4000, 16'h4000, 40'h00_7000_0000, 0, 0, 0, 2'b01, 0);
    check_bit("R7 lim down direct", lim_out, 1'b0);
    step("R7 lim up", 1, 16'h0000, 16'h0000, 40'h00_4000_0000, 0, 0, 0, 2'b10, 0);
    check_bit("R7 lim up direct", lim_out, 1'b1);
    // R9 hold while idle
    step("R9 idle", 0, 16'h7FFF, 16'h7FFF, 40'h12_3456_7890, 1, 1, 1, 2'b01, 0);
    // R6 saturation both directions
    step("R6 sat pos", 1, 16'h4000, 16'h4000, 40'h00_7FFF_0000, 0, 1, 0, 2'b00, 0);
    check_acc("R6 sat pos direct", acc_out, 40'h00_7FFF_0000);
    check_bit("R8 sat sets ovf", ovf_sticky, 1'b1);
    step("R8 clear", 0, 0, 0, 0, 0, 0, 0, 2'b00, 1);
    check_bit("R8 clear direct", ovf_sticky, 1'b0);
    step("R6 sat neg", 1, 16'h4000, 16'h4000, 40'hFF_8000_0000, 1, 1, 0, 2'b00, 0);
    check_acc("R6 sat neg direct", acc_out, 40'hFF_8000_0000);
    // R8 same-cycle event and clear: stays set
    step("R8 set wins", 1, 16'h4000, 16'h4000, 40'h00_7FFF_0000, 0, 1, 0, 2'b00, 1);
    check_bit("R8 set wins direct", ovf_sticky, 1'b1);
    step("R8 clear op", 1, 16'h0001, 16'h0001, 40'h0, 0, 1, 0, 2'b00, 1);
    // R8 40-bit wrap without saturation
    step("R8 wrap", 1, 16'h4000, 16'h4000, 40'h7F_FFFF_0000, 0, 0, 0, 2'b00, 0);
    check_acc("R8 wrap direct", acc_out, 40'h80_1FFF_0000);
    step("R8 clear2", 0, 0, 0, 0, 0, 0, 0, 2'b00, 1);
    // R2 -1 x -1: clamp keeps the result below the tie, no saturation
    step("R2 clamp", 1, 16'h8000, 16'h8000, 40'hFF_FFFF_8000, 0, 1, 0, 2'b00, 0);
    check_acc("R2 clamp direct", acc_out, 40'h00_7FFF_0000);
    check_bit("R2 clamp no ovf", ovf_sticky, 1'b0);
    step("R2 exact", 1, 16'h8000, 16'h8000, 40'h00_0000_0000, 0, 0, 0, 2'b00, 0);
    check_acc("R2 exact direct", acc_out, 40'h00_8000_0000);

    // R1 broad random coverage of all controls
    for (int i = 0; i < 3000; i++) begin
      logic [39:0] ra;
      ra = {$urandom, $urandom};
      if (i % 3 == 0) ra = {{9{ra[39]}}, ra[30:0]};
      step("R1 random", ($urandom % 4) != 0, 16'($urandom), 16'($urandom), ra,
           1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
           ($urandom % 8) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule